// File: doc/BRIEF.md
# Debug Comparator Match Unit

This block holds a small bank of hardware breakpoint comparators and a bank of watchpoint comparators. It decides, for each check request, whether any of them fires against the current access context. Each comparator has a control word and a value word. Both are loaded through a single write port. A check request supplies the program counter and a per-watchpoint hit vector from the address-compare logic. It also supplies the exception level, the security state, an unprivileged-access flag for the data access, and the current context identifier.

Each comparator first needs its own enable and a raw hit. For a breakpoint the raw hit is an exact PC match; for a watchpoint it is the hit bit supplied for it. The hit is then filtered by a security-state field and by a per-level privilege mask. A comparator may also be linked to a context-identifier comparator held in the top slots of the breakpoint bank. All results are OR-combined into one breakpoint flag and one watchpoint flag, which are registered one cycle after the check strobe. Matching is blocked completely unless the global debug enable is set and debug exceptions are currently allowed.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset all comparator registers are zero and `res_valid`, `bp_match` and `wp_match` are low.
- R2: `res_valid` is high in exactly the cycle after a cycle with `chk_valid` high. `bp_match` and `wp_match` are low in every cycle that does not follow a check.
- R3: If `dbg_enable` (global enable, bit 15 of the debug control register) or `dbg_allowed` is low at the check, both match outputs are low.
- R4: A breakpoint needs control bit 0 (enable) set and its value word equal to `chk_pc`.
- R5: Watchpoint n needs control bit 0 set and `wp_hit[n]` high.
- R6: The security field, control bits [15:14], works as follows: 0 matches in either state, 2 matches only when `secure` is high, and 1 or 3 match only when `secure` is low.
- R7: At levels 2 and 3 a match needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R8: When `wp_user` is high, watchpoints use the level-0 rule whatever `cur_el` is. Breakpoints ignore `wp_user`.
- R9: With control bit 20 (link) set, the linked index in control bits [19:16] must lie in NUM_BP-NUM_CTX to NUM_BP-1. The breakpoint at that index must have bit 0 set and type bits [23:20] equal to 3. Otherwise the comparator does not match.
- R10: A linked context comparator passes only when `cur_el` is 0 or 1 and its value word equals `ctx_id`.
- R11: `bp_match` is the OR over all breakpoints and `wp_match` is the OR over all watchpoints.
- R12: A write with `wr_target` 0 selects the breakpoint bank and 1 selects the watchpoint bank. `wr_field` 0 selects the control word and 1 selects the value word. A check in the same cycle as the write still sees the old contents; the new word applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 1 | 0 breakpoint bank, 1 watchpoint bank |
| wr_field | input | 1 | 0 control word, 1 value word |
| wr_idx | input | IDX_W | Comparator index |
| wr_data | input | DATA_W | Write data |
| chk_valid | input | 1 | Check request strobe |
| chk_pc | input | DATA_W | Current program counter |
| wp_hit | input | NUM_WP | Per-watchpoint address hit |
| wp_user | input | 1 | Data access was unprivileged |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Secure state |
| ctx_id | input | DATA_W | Current context identifier (low bits) |
| dbg_enable | input | 1 | Global debug enable bit |
| dbg_allowed | input | 1 | Debug exceptions currently allowed |
| res_valid | output | 1 | Result cycle marker |
| bp_match | output | 1 | Some breakpoint matched |
| wp_match | output | 1 | Some watchpoint matched |

## Verification
The clocked properties assume that `chk_valid` is a known value in every cycle after reset. They also assume that the check context (`dbg_enable`, `dbg_allowed`, `wp_hit`) is stable for the whole cycle the strobe is sampled. The bench drives every input at the falling edge and holds it through the next rising edge. It keeps `chk_valid` low during reset and between checks, so each check produces an isolated result cycle. Comparator contents change only through the write port, either before a check or, in the one overlap case, in the same cycle.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
    localparam int EN_BIT    = 0;
    localparam int PRIV1_BIT = 1;
    localparam int PRIV0_BIT = 2;
    localparam int HIGH_BIT  = 13;
    localparam int SEC_LO    = 14;
    localparam int LNK_LO    = 16;
    localparam int LNK_W     = 4;
    localparam int LINK_BIT  = 20;
    localparam int TYPE_LO   = 20;
    localparam int TYPE_W    = 4;
    localparam logic [TYPE_W-1:0] CTX_TYPE = 4'd3;

    function automatic logic sec_pass(input logic [1:0] sel, input logic is_sec);
        case (sel)
            2'd0:    return 1'b1;
            2'd2:    return is_sec;
            default: return !is_sec;
        endcase
    endfunction

    function automatic logic priv_pass(input logic [31:0] ctl, input logic [1:0] lvl);
        case (lvl)
            2'd0:    return ctl[PRIV0_BIT];
            2'd1:    return ctl[PRIV1_BIT];
            default: return ctl[HIGH_BIT];
        endcase
    endfunction
endpackage

// File: rtl/dbgm_regbank.sv
module dbgm_regbank #(
    parameter int NUM    = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_field,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM-1:0][DATA_W-1:0] ctrl,
    output logic [NUM-1:0][DATA_W-1:0] val
);
    typedef struct packed {
        logic [NUM-1:0][DATA_W-1:0] ctrl;
        logic [NUM-1:0][DATA_W-1:0] val;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_idx) < NUM)) begin
            if (wr_field) bank_d.val[wr_idx]  = wr_data;
            else          bank_d.ctrl[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign ctrl = bank_q.ctrl;
    assign val  = bank_q.val;
endmodule

// File: rtl/dbgm_ctxlink.sv
module dbgm_ctxlink
    import dbgm_pkg::*;
#(
    parameter int NUM_BP  = 4,
    parameter int NUM_CTX = 2,
    parameter int DATA_W  = 32
) (
    input  logic [NUM_BP-1:0][DATA_W-1:0] bp_ctrl,
    input  logic [NUM_BP-1:0][DATA_W-1:0] bp_val,
    input  logic [1:0]                    cur_el,
    input  logic [DATA_W-1:0]             ctx_id,
    output logic [NUM_BP-1:0]             ctx_ok
);
    localparam int FIRST_CTX = NUM_BP - NUM_CTX;

    for (genvar j = 0; j < NUM_BP; j++) begin : g_slot
        if (j >= FIRST_CTX) begin : g_ctx
            assign ctx_ok[j] = bp_ctrl[j][EN_BIT]
                            && (bp_ctrl[j][TYPE_LO +: TYPE_W] == CTX_TYPE)
                            && (cur_el <= 2'd1)
                            && (bp_val[j] == ctx_id);
        end else begin : g_plain
            assign ctx_ok[j] = 1'b0;
        end
    end
endmodule

// File: rtl/dbgm_qualify.sv
module dbgm_qualify
    import dbgm_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ctrl,
    input  logic              raw_hit,
    input  logic [1:0]        eff_el,
    input  logic              secure,
    input  logic [NUM_BP-1:0] ctx_ok,
    output logic              match
);
    logic [LNK_W-1:0] lnk_idx;
    logic             lnk_sel;
    logic             lnk_pass;

    assign lnk_idx = ctrl[LNK_LO +: LNK_W];

    always_comb begin
        lnk_sel = 1'b0;
        for (int j = 0; j < NUM_BP; j++) begin
            if (lnk_idx == LNK_W'(j)) lnk_sel = ctx_okj(j);
        end
    end

    function automatic logic ctx_okj(input int j);
        return ctx_ok[j];
    endfunction

    assign lnk_pass = !ctrl[LINK_BIT] || lnk_sel;
    assign match    = ctrl[EN_BIT] && raw_hit
                   && sec_pass(ctrl[SEC_LO +: 2], secure)
                   && priv_pass(ctrl[31:0], eff_el)
                   && lnk_pass;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbgm_pkg::*;
#(
    parameter int NUM_BP  = 4,
    parameter int NUM_WP  = 4,
    parameter int NUM_CTX = 2,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2((NUM_BP > NUM_WP) ? NUM_BP : NUM_WP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_target,
    input  logic              wr_field,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chk_valid,
    input  logic [DATA_W-1:0] chk_pc,
    input  logic [NUM_WP-1:0] wp_hit,
    input  logic              wp_user,
    input  logic [1:0]        cur_el,
    input  logic              secure,
    input  logic [DATA_W-1:0] ctx_id,
    input  logic              dbg_enable,
    input  logic              dbg_allowed,
    output logic              res_valid,
    output logic              bp_match,
    output logic              wp_match
);
    typedef struct packed {
        logic vld;
        logic bp;
        logic wp;
    } res_t;

    logic [NUM_BP-1:0][DATA_W-1:0] bp_ctrl, bp_val;
    logic [NUM_WP-1:0][DATA_W-1:0] wp_ctrl, wp_val;
    logic [NUM_BP-1:0]             ctx_ok;
    logic [NUM_BP-1:0]             bp_hit_vec;
    logic [NUM_WP-1:0]             wp_hit_vec;
    logic [1:0]                    wp_el;
    res_t                          res_d, res_q;

    dbgm_regbank #(.NUM(NUM_BP), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bp_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_target), .wr_field(wr_field),
        .wr_idx(wr_idx), .wr_data(wr_data), .ctrl(bp_ctrl), .val(bp_val)
    );

    dbgm_regbank #(.NUM(NUM_WP), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_wp_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_target), .wr_field(wr_field),
        .wr_idx(wr_idx), .wr_data(wr_data), .ctrl(wp_ctrl), .val(wp_val)
    );

    dbgm_ctxlink #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) u_ctx (
        .bp_ctrl(bp_ctrl), .bp_val(bp_val), .cur_el(cur_el), .ctx_id(ctx_id), .ctx_ok(ctx_ok)
    );

    assign wp_el = wp_user ? 2'd0 : cur_el;

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        dbgm_qualify #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_q (
            .ctrl(bp_ctrl[i]), .raw_hit(bp_val[i] == chk_pc), .eff_el(cur_el),
            .secure(secure), .ctx_ok(ctx_ok), .match(bp_hit_vec[i])
        );
    end

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        dbgm_qualify #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_q (
            .ctrl(wp_ctrl[i]), .raw_hit(wp_hit[i]), .eff_el(wp_el),
            .secure(secure), .ctx_ok(ctx_ok), .match(wp_hit_vec[i])
        );
    end

    always_comb begin
        res_d     = '0;
        res_d.vld = chk_valid;
        if (chk_valid && dbg_enable && dbg_allowed) begin
            res_d.bp = |bp_hit_vec;
            res_d.wp = |wp_hit_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign bp_match  = res_q.bp;
    assign wp_match  = res_q.wp;

    // R2
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!res_valid && !bp_match && !wp_match));

    // R3
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !(dbg_enable && dbg_allowed)) |=> (!bp_match && !wp_match));

    // R5
    wp_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && wp_hit == '0) |=> !wp_match);
endmodule

// File: tb/dbg_match_unit_tb_top.sv
module dbg_match_unit_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 0, wr_target = 0, wr_field = 0;
    logic [1:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          chk_valid = 0;
    logic [DW-1:0] chk_pc = '0;
    logic [3:0]    wp_hit = '0;
    logic          wp_user = 0;
    logic [1:0]    cur_el = 2'd1;
    logic          secure = 0;
    logic [DW-1:0] ctx_id = '0;
    logic          dbg_enable = 1, dbg_allowed = 1;
    logic          res_valid, bp_match, wp_match;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dbg_match_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target), .wr_field(wr_field),
        .wr_idx(wr_idx), .wr_data(wr_data), .chk_valid(chk_valid), .chk_pc(chk_pc),
        .wp_hit(wp_hit), .wp_user(wp_user), .cur_el(cur_el), .secure(secure), .ctx_id(ctx_id),
        .dbg_enable(dbg_enable), .dbg_allowed(dbg_allowed), .res_valid(res_valid),
        .bp_match(bp_match), .wp_match(wp_match)
    );

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic tgt, input logic fld, input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_target = tgt; wr_field = fld; wr_idx = 2'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // one check: inputs held from a falling edge through the rising edge, result read at next fall
    task automatic chk(input string tag, input logic [DW-1:0] pc, input logic [3:0] hit,
                       input logic usr, input logic [1:0] el, input logic sec,
                       input logic [DW-1:0] ctx, input logic exp_bp, input logic exp_wp);
        @(negedge clk);
        chk_valid = 1; chk_pc = pc; wp_hit = hit; wp_user = usr;
        cur_el = el; secure = sec; ctx_id = ctx;
        @(negedge clk);
        chk_valid = 0;
        expect_bit({tag, " bp"}, bp_match, exp_bp);
        expect_bit({tag, " wp"}, wp_match, exp_wp);
    endtask

    task automatic t_reset();
        expect_bit("R1 res_valid", res_valid, 1'b0);
        expect_bit("R1 bp", bp_match, 1'b0);
        expect_bit("R1 wp", wp_match, 1'b0);
        chk("R1 empty bank", 32'h0, 4'b0000, 0, 2'd1, 0, 32'h0, 0, 0);
    endtask

    task automatic t_timing();
        wr(0, 0, 0, 32'h2007);
        wr(0, 1, 0, 32'h1000);
        @(negedge clk);
        chk_valid = 1; chk_pc = 32'h1000; cur_el = 2'd1;
        @(negedge clk);
        chk_valid = 0;
        expect_bit("R2 valid after check", res_valid, 1'b1);
        expect_bit("R2 bp after check", bp_match, 1'b1);
        @(negedge clk);
        expect_bit("R2 valid idle", res_valid, 1'b0);
        expect_bit("R2 bp idle", bp_match, 1'b0);
    endtask

    task automatic t_addr();
        chk("R4 pc equal", 32'h1000, 0, 0, 2'd1, 0, 0, 1, 0);
        chk("R4 pc differs", 32'h1004, 0, 0, 2'd1, 0, 0, 0, 0);
        wr(0, 0, 0, 32'h2006);
        chk("R4 disabled", 32'h1000, 0, 0, 2'd1, 0, 0, 0, 0);
        wr(0, 0, 0, 32'h2007);
    endtask

    task automatic t_gate();
        dbg_enable = 0;
        chk("R3 global off", 32'h1000, 0, 0, 2'd1, 0, 0, 0, 0);
        dbg_enable = 1; dbg_allowed = 0;
        chk("R3 not allowed", 32'h1000, 0, 0, 2'd1, 0, 0, 0, 0);
        dbg_allowed = 1;
    endtask

    task automatic t_security();
        wr(0, 0, 0, 32'hA007);
        chk("R6 sel2 nonsecure", 32'h1000, 0, 0, 2'd1, 0, 0, 0, 0);
        chk("R6 sel2 secure", 32'h1000, 0, 0, 2'd1, 1, 0, 1, 0);
        wr(0, 0, 0, 32'h6007);
        chk("R6 sel1 secure", 32'h1000, 0, 0, 2'd1, 1, 0, 0, 0);
        chk("R6 sel1 nonsecure", 32'h1000, 0, 0, 2'd1, 0, 0, 1, 0);
        wr(0, 0, 0, 32'hE007);
        chk("R6 sel3 secure", 32'h1000, 0, 0, 2'd1, 1, 0, 0, 0);
        wr(0, 0, 0, 32'h2007);
        chk("R6 sel0 secure", 32'h1000, 0, 0, 2'd1, 1, 0, 1, 0);
    endtask

    task automatic t_priv();
        wr(0, 0, 0, 32'h0003);
        chk("R7 bit1 at el1", 32'h1000, 0, 0, 2'd1, 0, 0, 1, 0);
        chk("R7 bit1 at el0", 32'h1000, 0, 0, 2'd0, 0, 0, 0, 0);
        chk("R7 bit1 at el2", 32'h1000, 0, 0, 2'd2, 0, 0, 0, 0);
        chk("R8 bp ignores user", 32'h1000, 0, 1, 2'd1, 0, 0, 1, 0);
        wr(0, 0, 0, 32'h2001);
        chk("R7 bit13 at el3", 32'h1000, 0, 0, 2'd3, 0, 0, 1, 0);
        chk("R7 bit13 at el1", 32'h1000, 0, 0, 2'd1, 0, 0, 0, 0);
        wr(0, 0, 0, 32'h0005);
        chk("R7 bit2 at el0", 32'h1000, 0, 0, 2'd0, 0, 0, 1, 0);
        wr(0, 0, 0, 32'h2007);
    endtask

    task automatic t_watch();
        wr(1, 0, 1, 32'h0003);
        chk("R5 wp1 hit", 32'h0, 4'b0010, 0, 2'd1, 0, 0, 0, 1);
        chk("R5 wp0 disabled", 32'h0, 4'b0001, 0, 2'd1, 0, 0, 0, 0);
        chk("R8 user forces el0", 32'h0, 4'b0010, 1, 2'd1, 0, 0, 0, 0);
        wr(1, 0, 1, 32'h0005);
        chk("R8 user at el2", 32'h0, 4'b0010, 1, 2'd2, 0, 0, 0, 1);
        chk("R8 no user at el2", 32'h0, 4'b0010, 0, 2'd2, 0, 0, 0, 0);
    endtask

    task automatic t_link();
        wr(0, 0, 3, 32'h0030_2007);
        wr(0, 1, 3, 32'hC0DE_0001);
        wr(0, 0, 0, 32'h0013_2007);
        wr(0, 1, 0, 32'h2000);
        chk("R10 ctx equal el1", 32'h2000, 0, 0, 2'd1, 0, 32'hC0DE_0001, 1, 0);
        chk("R10 ctx differs", 32'h2000, 0, 0, 2'd1, 0, 32'hC0DE_0002, 0, 0);
        chk("R10 ctx at el2", 32'h2000, 0, 0, 2'd2, 0, 32'hC0DE_0001, 0, 0);
        wr(0, 0, 0, 32'h0011_2007);
        chk("R9 index below range", 32'h2000, 0, 0, 2'd1, 0, 32'hC0DE_0001, 0, 0);
        wr(0, 0, 0, 32'h0012_2007);
        chk("R9 linked disabled", 32'h2000, 0, 0, 2'd1, 0, 32'hC0DE_0001, 0, 0);
        wr(0, 0, 2, 32'h0020_2007);
        wr(0, 1, 2, 32'hC0DE_0001);
        chk("R9 linked wrong type", 32'h2000, 0, 0, 2'd1, 0, 32'hC0DE_0001, 0, 0);
        wr(1, 0, 2, 32'h0013_2007);
        chk("R9 wp linked el0", 32'h0, 4'b0100, 0, 2'd0, 0, 32'hC0DE_0001, 0, 1);
        wr(0, 0, 0, 32'h2007);
        wr(0, 1, 0, 32'h1000);
    endtask

    task automatic t_or_and_write();
        wr(0, 0, 1, 32'h2007);
        wr(0, 1, 1, 32'h3000);
        chk("R11 second bp", 32'h3000, 4'b0010, 0, 2'd0, 0, 0, 1, 1);
        @(negedge clk);
        wr_en = 1; wr_target = 0; wr_field = 1; wr_idx = 2'd1; wr_data = 32'h4000;
        chk_valid = 1; chk_pc = 32'h4000; wp_hit = 0; cur_el = 2'd1;
        @(negedge clk);
        wr_en = 0; chk_valid = 0;
        expect_bit("R12 same cycle old value", bp_match, 1'b0);
        chk("R12 new value used", 32'h4000, 0, 0, 2'd1, 0, 0, 1, 0);
        chk("R12 old value gone", 32'h3000, 0, 0, 2'd1, 0, 0, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timing();
        t_addr();
        t_gate();
        t_security();
        t_priv();
        t_watch();
        t_link();
        t_or_and_write();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule